// File: doc/BRIEF.md
# GHASH Field Multiplier

This block multiplies two 128-bit blocks in GF(2^128), the field used by the GCM authentication hash, and reduces the product modulo x^128 + x^7 + x^2 + x + 1. A caller presents both operands together with a valid strobe. The block takes them when it is idle. It strobes the reduced product on its output one cycle later than the 32 cycles of multiplication. Operands and result are exchanged in memory byte order. The block reverses the bytes on the way in and on the way out.

Inside, each operand is split into two 64-bit halves. Four 64x64 carry-less partial products are formed one after another by a single iterative multiplier that consumes 8 bits of one operand per clock. The low-by-low and high-by-high products and the XOR of the two cross products are kept. In a final cycle the 256-bit product is formed and shifted one bit left to undo the reflected bit order. It is then folded back to 128 bits in two shift-and-XOR passes that work on 32-bit lanes. One pass shifts left by 31, 30 and 25. The other shifts right by 1, 2 and 7.

Top module: `gf128_hash_mul`

## Requirements
- R1: Byte k of a port block sits at bits [8k+7:8k] of `in_a`, `in_b` and `out_data`, and byte 0 is the first byte of the block. Bit 7 of byte 0 is the coefficient of x^0, and bit 0 of byte 15 is the coefficient of x^127.
- R2: `out_data` equals the product of the two accepted operands in GF(2^128) modulo x^128 + x^7 + x^2 + x + 1. All sums are XOR.
- R3: The field's one, a block whose only set bit is bit 7 of byte 0 (`128'h80`), used as either operand returns the other operand unchanged. Swapping the operands does not change the result.
- R4: A zero operand on either input gives an all-zero result.
- R5: An operand pair is taken at a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the edge after that until the result is produced.
- R6: `in_valid` and the operand values presented while `in_ready` is low are ignored: the pending result is unchanged and no extra result is produced.
- R7: `out_valid` is high for exactly one cycle, and it rises at the 33rd rising edge after the accepting edge.
- R8: `out_data` changes only at the edge where `out_valid` rises. At all other edges it keeps its value.
- R9: A synchronous active-low reset `rst_n` sets `in_ready` to 1, `out_valid` to 0 and `out_data` to 0.
- R10: `in_ready` is high in the cycle where `out_valid` is high, so a new pair can be taken at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block idle, pair will be taken |
| in_a | input | 128 | First operand, memory byte order |
| in_b | input | 128 | Second operand, memory byte order |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 128 | Reduced product, memory byte order |

## Verification
A wrong partial-product index or a lost cross-product term corrupts the result without touching the handshake. It shows up only as a data mismatch at the strobe, 33 edges after the accept, so every result is compared against a bit-serial field multiply that works one bit at a time. A stuck or miscounted sequencer shows at the ports as a strobe arriving at the wrong edge or not at all, or as `in_ready` rising early. Each result's latency is therefore measured in edges, and traffic presented while the block is busy must leave both the pending result and the strobe count untouched.

// File: rtl/gfm_pkg.sv
// Shared definitions for the GHASH field multiplier.
// Assumes 128-bit blocks exchanged in memory byte order.
package gfm_pkg;

    localparam int BLK_W  = 128;
    localparam int HALF_W = BLK_W / 2;
    localparam int NBYTES = BLK_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_RED  = 2'd2
    } gfm_state_t;

    // Reverse the byte order of a block (memory order <-> big-endian integer).
    function automatic logic [BLK_W-1:0] flip_bytes(input logic [BLK_W-1:0] v);
        logic [BLK_W-1:0] r;
        for (int i = 0; i < NBYTES; i++) begin
            r[8*i +: 8] = v[8*(NBYTES-1-i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/gfm_clmul_iter.sv
// Iterative carry-less multiplier: OP_W x OP_W -> 2*OP_W bits.
// Consumes STEP_W bits of operand b per clock, most significant chunk first.
// The start edge performs the first step. 'done' pulses in the cycle after the
// last step, and 'prod' holds until the next start.
// Assumes OP_W is a multiple of STEP_W and start is raised only when not busy.
module gfm_clmul_iter #(
    parameter int OP_W   = 64,
    parameter int STEP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [OP_W-1:0]     a,
    input  logic [OP_W-1:0]     b,
    output logic                done,
    output logic [2*OP_W-1:0]   prod
);
    localparam int PW    = 2 * OP_W;
    localparam int NSTEP = OP_W / STEP_W;
    localparam int CW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;

    logic [OP_W-1:0]   a_q, b_q;
    logic [PW-1:0]     acc_q;
    logic [CW-1:0]     cnt_q;
    logic              busy_q, done_q;

    logic [OP_W-1:0]   src_a;
    logic [STEP_W-1:0] chunk;
    logic [PW-1:0]     base;
    logic [PW-1:0]     terms [STEP_W];
    logic [PW-1:0]     part;

    // Pick the operand source: fresh inputs on start, held registers otherwise.
    always_comb begin
        src_a = start ? a : a_q;
        chunk = start ? b[OP_W-1 -: STEP_W] : b_q[OP_W-1 -: STEP_W];
        base  = start ? '0 : acc_q;
    end

    // One shifted copy of a for every bit of the current chunk.
    for (genvar j = 0; j < STEP_W; j++) begin : g_term
        assign terms[j] = chunk[j] ? (PW'(src_a) << j) : '0;
    end

    // XOR-fold the shifted copies into one chunk product.
    always_comb begin
        part = '0;
        for (int j = 0; j < STEP_W; j++) begin
            part = part ^ terms[j];
        end
    end

    // Horner-style accumulate: shift by one chunk and add the new chunk product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                a_q    <= a;
                b_q    <= b << STEP_W;
                acc_q  <= (base << STEP_W) ^ part;
                cnt_q  <= CW'(1);
                busy_q <= (NSTEP > 1);
                done_q <= (NSTEP == 1);
            end else if (busy_q) begin
                b_q   <= b_q << STEP_W;
                acc_q <= (base << STEP_W) ^ part;
                cnt_q <= cnt_q + CW'(1);
                if (cnt_q == CW'(NSTEP - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign prod = acc_q;
endmodule

// File: rtl/gfm_reduce.sv
// Combinational assembly, reflection shift and two-pass reduction.
// Inputs are the low-by-low product, the XOR of both cross products and the
// high-by-high product of two big-endian 128-bit operands. Output is the
// reduced field product, still in big-endian integer form.
module gfm_reduce
    import gfm_pkg::*;
(
    input  logic [BLK_W-1:0] p_ll,
    input  logic [BLK_W-1:0] p_mid,
    input  logic [BLK_W-1:0] p_hh,
    output logic [BLK_W-1:0] result
);
    localparam int LANE_W = 32;
    localparam int NLANE  = BLK_W / LANE_W;

    logic [BLK_W-1:0] lo, hi, lo_s, hi_s, t_fold, lo_p1, keep, u_fold, lo_p2;

    // Build the 256-bit product and shift it one bit left across both words.
    always_comb begin
        lo   = p_ll ^ (p_mid << HALF_W);
        hi   = p_hh ^ (p_mid >> HALF_W);
        lo_s = lo << 1;
        hi_s = {hi[BLK_W-2:0], lo[BLK_W-1]};
    end

    // First pass: per-lane left shifts of the low word.
    for (genvar g = 0; g < NLANE; g++) begin : g_pass1
        assign t_fold[LANE_W*g +: LANE_W] = (lo_s[LANE_W*g +: LANE_W] << 31)
                                          ^ (lo_s[LANE_W*g +: LANE_W] << 30)
                                          ^ (lo_s[LANE_W*g +: LANE_W] << 25);
    end

    // Fold the top lane of the first pass in and keep the rest for later.
    always_comb begin
        lo_p1 = lo_s ^ (t_fold << (3 * LANE_W));
        keep  = t_fold >> LANE_W;
    end

    // Second pass: per-lane right shifts of the updated low word.
    for (genvar g = 0; g < NLANE; g++) begin : g_pass2
        assign u_fold[LANE_W*g +: LANE_W] = (lo_p1[LANE_W*g +: LANE_W] >> 1)
                                          ^ (lo_p1[LANE_W*g +: LANE_W] >> 2)
                                          ^ (lo_p1[LANE_W*g +: LANE_W] >> 7);
    end

    // Merge the second pass and add the reduced low word into the high word.
    always_comb begin
        lo_p2  = lo_p1 ^ u_fold ^ keep;
        result = hi_s ^ lo_p2;
    end
endmodule

// File: rtl/gf128_hash_mul.sv
// GHASH multiplier top: handshake, operand byte reversal, sequencing of four
// partial products through one iterative carry-less multiplier, reduction and
// output byte reversal. Assumes the caller holds in_a/in_b valid with in_valid.
module gf128_hash_mul
    import gfm_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BLK_W-1:0]  in_a,
    input  logic [BLK_W-1:0]  in_b,
    output logic              out_valid,
    output logic [BLK_W-1:0]  out_data
);
    gfm_state_t        st_q;
    logic [1:0]        idx_q, nxt_idx;
    logic [BLK_W-1:0]  a_q, b_q, ll_q, mid_q, hh_q, res_q;
    logic              vld_q;

    logic [BLK_W-1:0]  a_sw, b_sw, src_a, src_b, red_out;
    logic [HALF_W-1:0] op_x, op_y;
    logic              accept, mul_start, mul_done;
    logic [BLK_W-1:0]  mul_prod;

    // Handshake and next-product decision.
    always_comb begin
        a_sw      = flip_bytes(in_a);
        b_sw      = flip_bytes(in_b);
        accept    = in_valid && (st_q == ST_IDLE);
        mul_start = accept || ((st_q == ST_MUL) && mul_done && (idx_q != 2'd3));
        nxt_idx   = accept ? 2'd0 : idx_q + 2'd1;
        src_a     = accept ? a_sw : a_q;
        src_b     = accept ? b_sw : b_q;
    end

    // Select the halves for the next partial product.
    always_comb begin
        unique case (nxt_idx)
            2'd0:    begin op_x = src_a[HALF_W-1:0];     op_y = src_b[HALF_W-1:0];     end
            2'd1:    begin op_x = src_a[HALF_W-1:0];     op_y = src_b[BLK_W-1:HALF_W]; end
            2'd2:    begin op_x = src_a[BLK_W-1:HALF_W]; op_y = src_b[HALF_W-1:0];     end
            default: begin op_x = src_a[BLK_W-1:HALF_W]; op_y = src_b[BLK_W-1:HALF_W]; end
        endcase
    end

    gfm_clmul_iter #(.OP_W(HALF_W), .STEP_W(STEP_W)) u_clmul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (op_x),
        .b     (op_y),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    gfm_reduce u_reduce (
        .p_ll   (ll_q),
        .p_mid  (mid_q),
        .p_hh   (hh_q),
        .result (red_out)
    );

    // Sequencer: capture operands, collect partial products, emit the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= 2'd0;
            a_q   <= '0;
            b_q   <= '0;
            ll_q  <= '0;
            mid_q <= '0;
            hh_q  <= '0;
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        a_q   <= a_sw;
                        b_q   <= b_sw;
                        idx_q <= 2'd0;
                        st_q  <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    if (mul_done) begin
                        unique case (idx_q)
                            2'd0:    ll_q  <= mul_prod;
                            2'd1:    mid_q <= mul_prod;
                            2'd2:    mid_q <= mid_q ^ mul_prod;
                            default: begin
                                hh_q <= mul_prod;
                                st_q <= ST_RED;
                            end
                        endcase
                        idx_q <= idx_q + 2'd1;
                    end
                end
                default: begin
                    res_q <= flip_bytes(red_out);
                    vld_q <= 1'b1;
                    st_q  <= ST_IDLE;
                end
            endcase
        end
    end

    assign in_ready  = (st_q == ST_IDLE);
    assign out_valid = vld_q;
    assign out_data  = res_q;
endmodule

// File: rtl/gf128_hash_mul_chk.sv
// Port-level protocol checker for gf128_hash_mul, attached by bind.
// Assumes the default step width (33-edge latency).
module gf128_hash_mul_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic [127:0] out_data
);
    localparam int LAT = 33;

    logic [6:0] lat_q;

    // Count edges since the last accepted pair, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else if (in_valid && in_ready) lat_q <= '0;
        else if (lat_q != 7'h7f) lat_q <= lat_q + 7'd1;
    end

    assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_strobe_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_q == 7'(LAT)));

    assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    assert_ready_with_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);
endmodule

bind gf128_hash_mul gf128_hash_mul_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/gf128_hash_mul_test.sv
// Scoreboard bench: driver pushes expected results, monitor pops and compares.
module gf128_hash_mul_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_a = '0, in_b = '0;
    logic         in_ready, out_valid;
    logic [127:0] out_data;

    int checks = 0, fails = 0, cyc = 0;
    logic [127:0] exp_q[$];
    int           tacc_q[$];
    logic [127:0] last_out = '0;
    logic         mon_on = 1'b0;

    gf128_hash_mul uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Port byte order to big-endian integer and back.
    function automatic logic [127:0] rev(input logic [127:0] v);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) r[8*k +: 8] = v[8*(15-k) +: 8];
        return r;
    endfunction

    // Bit-serial field multiply on big-endian integers (x^0 at bit 127).
    function automatic logic [127:0] ref_mul(input logic [127:0] x, input logic [127:0] y);
        logic [127:0] z = '0, v = y;
        for (int i = 0; i < 128; i++) begin
            if (x[127-i]) z = z ^ v;
            if (v[0]) v = (v >> 1) ^ {8'he1, 120'b0};
            else      v = v >> 1;
        end
        return z;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: wait for ready, present a pair, record the accept edge.
    task automatic issue(input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b;
        @(posedge clk);
        #1;
        exp_q.push_back(rev(ref_mul(rev(a), rev(b))));
        tacc_q.push_back(cyc);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare results, latency and hold of out_data.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6 actual=unexpected result %h expected=no result", out_data);
                end else begin
                    int t;
                    logic [127:0] e;
                    e = exp_q.pop_front();
                    t = tacc_q.pop_front();
                    check("R2", out_data, e);
                    check("R7", 128'(cyc - t), 128'd33);
                end
            end else begin
                check("R8", out_data, last_out);
            end
            last_out = out_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] x, y, one;
        one = 128'h80;
        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9 ready", 128'(in_ready), 128'd1);
        check("R9 valid", 128'(out_valid), 128'd0);
        check("R9 data", out_data, 128'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R4: zero operands
        issue('0, rnd128());
        issue(rnd128(), '0);
        drain();
        check("R4 zero", out_data, 128'd0);

        // R3: identity on both sides, and R1 byte order through the identity
        y = rnd128();
        issue(one, y);
        drain();
        check("R3 one*y", out_data, y);
        issue(y, one);
        drain();
        check("R3 y*one", out_data, y);
        // R1: x (bit 6 of byte 0) times x gives x^2 (bit 5 of byte 0)
        issue(128'h40, 128'h40);
        drain();
        check("R1 x*x", out_data, 128'h20);
        // R1: x^127 (bit 0 of byte 15) times x wraps to x^7+x^2+x+1
        issue(128'h01 << 120, 128'h40);
        drain();
        check("R1 wrap", out_data, 128'he1);

        // R3: commutativity
        x = rnd128(); y = rnd128();
        issue(x, y);
        drain();
        last_out = out_data;
        issue(y, x);
        drain();
        check("R3 swap", out_data, rev(ref_mul(rev(x), rev(y))));

        // R2: random pairs, back to back through the driver
        for (int n = 0; n < 20; n++) issue(rnd128(), rnd128());
        drain();

        // R5/R6: traffic while busy is ignored
        issue(rnd128(), rnd128());
        @(negedge clk);
        check("R5 busy", 128'(in_ready), 128'd0);
        in_valid = 1'b1; in_a = rnd128(); in_b = rnd128();
        repeat (20) @(negedge clk);
        check("R5 still busy", 128'(in_ready), 128'd0);
        in_valid = 1'b0;
        drain();

        // R10: new pair taken in the strobe cycle
        issue(rnd128(), rnd128());
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        check("R10 ready", 128'(in_ready), 128'd1);
        x = rnd128(); y = rnd128();
        in_valid = 1'b1; in_a = x; in_b = y;
        @(posedge clk);
        #1;
        exp_q.push_back(rev(ref_mul(rev(x), rev(y))));
        tacc_q.push_back(cyc);
        in_valid = 1'b0;
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule